// File: doc/BRIEF.md
# Collision Retry and Abort Controller

This block follows one frame at a time through half-duplex transmission and decides what each transmit attempt's ending means. The transmit path signals the start of an attempt, one strobe per byte sent after the start-of-frame delimiter, a collision indication and the end of the frame. The block counts the strobes in the current attempt and compares that count with a programmable collision window. A collision inside the window asks for an automatic retry. A collision past the window is reported as late. When the retry budget is used up, the frame is dropped with an excess-collision status.

Each attempt ends with exactly one single-cycle outcome pulse: retry, done-OK, excess-collision abort or late collision. The transmit path then computes its backoff and raises `frame_start` again when it wants another try. Software sees one 32-bit configuration word. It holds the collision window in bits 13:8 and the retry limit in bits 3:0. Every other bit reads as zero.

Top module: `coll_retry_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x0000370F (window 0x37, retry limit 0xF) and all four outcome pulses are low.
- R2: A write with `cfg_we` high stores bits 13:8 as the window and bits 3:0 as the retry limit. All other bits of `cfg_rdata` read zero, whatever was written.
- R3: The byte count is the number of `byte_tx` strobes seen since the most recent `frame_start`. Each `frame_start` clears it, so a restarted attempt counts from zero.
- R4: A collision in an active attempt whose byte count is below the window, while fewer retries than the limit have been spent, gives `retry_pulse` on the next cycle and uses up one retry.
- R5: A collision in an active attempt whose byte count is equal to or above the window gives `late_coll_pulse` and no retry, and the retry count returns to zero.
- R6: An in-window collision that arrives when the retries spent equal the limit gives `abort_excess_pulse` instead of a retry. With limit N, the frame aborts on collision N+1. The retry count then returns to zero.
- R7: `frame_end` in an active attempt with no collision in the same cycle gives `done_ok_pulse` and returns the retry count to zero.
- R8: At most one outcome pulse is high in any cycle. After an outcome the attempt is over, and `collision` and `frame_end` have no effect until the next `frame_start`.
- R9: When `collision` and `frame_end` are high in the same cycle, the collision decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data; reserved bits are zero |
| frame_start | input | 1 | Begins a transmit attempt and clears the byte count |
| byte_tx | input | 1 | One pulse per byte sent after the start-of-frame delimiter |
| collision | input | 1 | Collision detected on the medium |
| frame_end | input | 1 | Last byte of the frame has been sent |
| retry_pulse | output | 1 | Attempt ended by an in-window collision; retry requested |
| done_ok_pulse | output | 1 | Frame sent without collision |
| abort_excess_pulse | output | 1 | Retry limit exceeded; frame dropped |
| late_coll_pulse | output | 1 | Collision after the window |

## Verification
A table of window and byte-count pairs places collisions one byte below and exactly at the window, including windows of 0 and 63. This separates a strict compare from an inclusive one and catches an off-by-one in the counter. Abort sequences with limits 0 and 3 show whether the abort comes on collision N+1 rather than N or N+2. Sequences that put a late collision or a good frame between retries show whether each of them really clears the retry count. Directed cases cover same-cycle collision and frame end, stray inputs after an outcome, and an attempt restarted part way through its bytes.

// File: rtl/coll_retry_pkg.sv
package coll_retry_pkg;

    localparam int REG_W   = 32;
    localparam int WIN_W   = 6;
    localparam int RETRY_W = 4;
    localparam int WIN_LSB = 8;
    localparam int LIM_LSB = 0;
    localparam int CNT_W   = WIN_W + 1;

    localparam logic [WIN_W-1:0]   WIN_RST   = 6'h37;
    localparam logic [RETRY_W-1:0] LIMIT_RST = 4'hF;

    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_RETRY,
        OUT_LATE,
        OUT_ABORT,
        OUT_OK
    } outcome_e;

    typedef struct packed {
        logic [WIN_W-1:0]   window;
        logic [RETRY_W-1:0] limit;
    } coll_cfg_t;

    function automatic logic [REG_W-1:0] cfg_pack(coll_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[WIN_LSB +: WIN_W]   = c.window;
        w[LIM_LSB +: RETRY_W] = c.limit;
        return w;
    endfunction

    function automatic coll_cfg_t cfg_unpack(logic [REG_W-1:0] w);
        coll_cfg_t c;
        c.window = w[WIN_LSB +: WIN_W];
        c.limit  = w[LIM_LSB +: RETRY_W];
        return c;
    endfunction

endpackage

// File: rtl/coll_cfg_reg.sv
module coll_cfg_reg
    import coll_retry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output coll_cfg_t        cfg
);

    coll_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.window <= WIN_RST;
            cfg_q.limit  <= LIMIT_RST;
        end else if (we) begin
            cfg_q <= cfg_unpack(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_pack(cfg_q);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        $past(we) && !$past(rst) |-> cfg_q.window == $past(wdata[WIN_LSB +: WIN_W])
                                  && cfg_q.limit == $past(wdata[LIM_LSB +: RETRY_W]));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~(((REG_W)'((1 << WIN_W) - 1) << WIN_LSB)
                 | ((REG_W)'((1 << RETRY_W) - 1) << LIM_LSB))) == '0);

endmodule

// File: rtl/coll_byte_counter.sv
module coll_byte_counter
    import coll_retry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             byte_tx,
    input  logic [WIN_W-1:0] window,
    output logic             in_window
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (byte_tx && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign in_window = cnt_q < CNT_W'(window);

    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (rst)
        $past(restart) && !$past(rst) |-> cnt_q == '0);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(restart) && !$past(rst) |-> cnt_q - $past(cnt_q) <= CNT_W'(1));

endmodule

// File: rtl/coll_attempt_fsm.sv
module coll_attempt_fsm
    import coll_retry_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               collision,
    input  logic               frame_end,
    input  logic               in_window,
    input  logic [RETRY_W-1:0] limit,
    output outcome_e           outcome
);

    logic               active_q;
    logic [RETRY_W-1:0] retries_q;
    outcome_e           outcome_q;
    outcome_e           next_out;

    always_comb begin
        next_out = OUT_NONE;
        if (active_q) begin
            if (collision) begin
                if (!in_window)              next_out = OUT_LATE;
                else if (retries_q >= limit) next_out = OUT_ABORT;
                else                         next_out = OUT_RETRY;
            end else if (frame_end) begin
                next_out = OUT_OK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            retries_q <= '0;
            outcome_q <= OUT_NONE;
        end else begin
            outcome_q <= next_out;
            unique case (next_out)
                OUT_RETRY: begin
                    active_q  <= 1'b0;
                    retries_q <= retries_q + 1'b1;
                end
                OUT_LATE, OUT_ABORT, OUT_OK: begin
                    active_q  <= 1'b0;
                    retries_q <= '0;
                end
                default: if (frame_start) active_q <= 1'b1;
            endcase
        end
    end

    assign outcome = outcome_q;

    assert_outcome_needs_attempt_R8: assert property (@(posedge clk) disable iff (rst)
        outcome_q != OUT_NONE |-> $past(active_q));

    assert_abort_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
        outcome_q == OUT_ABORT |-> $past(retries_q) >= $past(limit) && $past(in_window));

    assert_retry_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        outcome_q == OUT_RETRY |-> $past(in_window) && $past(collision));

    assert_late_outside_R5: assert property (@(posedge clk) disable iff (rst)
        outcome_q == OUT_LATE |-> !$past(in_window) && retries_q == '0);

    assert_ok_clears_R7: assert property (@(posedge clk) disable iff (rst)
        outcome_q == OUT_OK |-> retries_q == '0 && !$past(collision));

endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
    import coll_retry_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        frame_start,
    input  logic        byte_tx,
    input  logic        collision,
    input  logic        frame_end,
    output logic        retry_pulse,
    output logic        done_ok_pulse,
    output logic        abort_excess_pulse,
    output logic        late_coll_pulse
);

    coll_cfg_t cfg;
    logic      in_window;
    outcome_e  outcome;

    coll_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    coll_byte_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart   (frame_start),
        .byte_tx   (byte_tx),
        .window    (cfg.window),
        .in_window (in_window)
    );

    coll_attempt_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .collision   (collision),
        .frame_end   (frame_end),
        .in_window   (in_window),
        .limit       (cfg.limit),
        .outcome     (outcome)
    );

    assign retry_pulse        = (outcome == OUT_RETRY);
    assign done_ok_pulse      = (outcome == OUT_OK);
    assign abort_excess_pulse = (outcome == OUT_ABORT);
    assign late_coll_pulse    = (outcome == OUT_LATE);

    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retry_pulse, done_ok_pulse, abort_excess_pulse, late_coll_pulse}));

    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (retry_pulse || done_ok_pulse || abort_excess_pulse || late_coll_pulse)
        |=> !(retry_pulse || done_ok_pulse || abort_excess_pulse || late_coll_pulse));

endmodule

// File: tb/tb_coll_retry_ctrl.sv
module tb_coll_retry_ctrl;

    localparam int CLK_PERIOD = 10;

    // outcome code: {retry, late, abort, ok}
    localparam logic [3:0] E_NONE  = 4'b0000;
    localparam logic [3:0] E_RETRY = 4'b1000;
    localparam logic [3:0] E_LATE  = 4'b0100;
    localparam logic [3:0] E_ABORT = 4'b0010;
    localparam logic [3:0] E_OK    = 4'b0001;

    // vector: {late_expected, bytes_before_collision[6:0], window[5:0]}
    localparam int NVEC = 7;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 7'd54, 6'd55},
        {1'b1, 7'd55, 6'd55},
        {1'b0, 7'd9,  6'd10},
        {1'b1, 7'd10, 6'd10},
        {1'b1, 7'd0,  6'd0},
        {1'b0, 7'd62, 6'd63},
        {1'b1, 7'd63, 6'd63}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frame_start = 1'b0;
    logic        byte_tx = 1'b0;
    logic        collision = 1'b0;
    logic        frame_end = 1'b0;
    logic        retry_pulse, done_ok_pulse, abort_excess_pulse, late_coll_pulse;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coll_retry_ctrl dut (
        .clk                (clk),
        .rst                (rst),
        .cfg_we             (cfg_we),
        .cfg_wdata          (cfg_wdata),
        .cfg_rdata          (cfg_rdata),
        .frame_start        (frame_start),
        .byte_tx            (byte_tx),
        .collision          (collision),
        .frame_end          (frame_end),
        .retry_pulse        (retry_pulse),
        .done_ok_pulse      (done_ok_pulse),
        .abort_excess_pulse (abort_excess_pulse),
        .late_coll_pulse    (late_coll_pulse)
    );

    function automatic logic [3:0] pulses();
        return {retry_pulse, late_coll_pulse, abort_excess_pulse, done_ok_pulse};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int win, input int lim);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 32'((win << 8) | lim);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic start_attempt();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_tx = 1'b1;
        end
        @(negedge clk);
        byte_tx = 1'b0;
    endtask

    // raise collision/frame_end for one cycle; the registered outcome is
    // visible during the following low phase, where it is sampled
    task automatic event_check(input logic col, input logic fend,
                               input logic [3:0] exp, input string req);
        @(negedge clk);
        collision = col;
        frame_end = fend;
        @(negedge clk);
        collision = 1'b0;
        frame_end = 1'b0;
        check(32'(pulses()), 32'(exp), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(cfg_rdata, 32'h0000_370F, "R1 reset config");
        check(32'(pulses()), 32'(E_NONE), "R1 reset pulses");

        // R2 field placement and reserved bits
        write_cfg(0, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata, 32'h0000_3F0F, "R2 reserved read zero");
        write_cfg(5, 9);
        check(cfg_rdata, 32'h0000_0509, "R2 field write");

        // table: collisions one byte below and at the window (R4, R5, R7)
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(int'(VEC[v][5:0]), 15);
            start_attempt();
            send_bytes(int'(VEC[v][12:6]));
            event_check(1'b1, 1'b0, VEC[v][13] ? E_LATE : E_RETRY,
                        VEC[v][13] ? "R5 late at window" : "R4 retry below window");
            start_attempt();
            event_check(1'b0, 1'b1, E_OK, "R7 good frame");
        end

        // R6 abort on collision limit+1
        write_cfg(55, 3);
        for (int k = 0; k < 3; k++) begin
            start_attempt();
            send_bytes(2);
            event_check(1'b1, 1'b0, E_RETRY, "R6 retry before limit");
        end
        start_attempt();
        event_check(1'b1, 1'b0, E_ABORT, "R6 abort after limit");
        // R8 stray inputs after an outcome do nothing
        event_check(1'b1, 1'b0, E_NONE, "R8 collision while idle");
        event_check(1'b0, 1'b1, E_NONE, "R8 frame_end while idle");
        // R6 retry count cleared by abort
        start_attempt();
        event_check(1'b1, 1'b0, E_RETRY, "R6 count cleared after abort");
        start_attempt();
        event_check(1'b0, 1'b1, E_OK, "R7 finish after abort");

        // R6 limit zero aborts on first collision
        write_cfg(55, 0);
        start_attempt();
        event_check(1'b1, 1'b0, E_ABORT, "R6 limit zero");

        // R5 late collision clears the retry count
        write_cfg(10, 2);
        start_attempt();
        event_check(1'b1, 1'b0, E_RETRY, "R5 pre retry");
        start_attempt();
        send_bytes(12);
        event_check(1'b1, 1'b0, E_LATE, "R5 late");
        start_attempt();
        event_check(1'b1, 1'b0, E_RETRY, "R5 cleared retry 1");
        start_attempt();
        event_check(1'b1, 1'b0, E_RETRY, "R5 cleared retry 2");
        start_attempt();
        event_check(1'b1, 1'b0, E_ABORT, "R5 then abort");

        // R7 good frame clears the retry count
        write_cfg(10, 1);
        start_attempt();
        event_check(1'b1, 1'b0, E_RETRY, "R7 pre retry");
        start_attempt();
        event_check(1'b0, 1'b1, E_OK, "R7 ok");
        start_attempt();
        event_check(1'b1, 1'b0, E_RETRY, "R7 cleared retry");
        start_attempt();
        event_check(1'b1, 1'b0, E_ABORT, "R7 then abort");

        // R9 collision wins over frame_end
        write_cfg(10, 15);
        start_attempt();
        event_check(1'b1, 1'b1, E_RETRY, "R9 collision priority");
        start_attempt();
        send_bytes(11);
        event_check(1'b1, 1'b1, E_LATE, "R9 late priority");

        // R3 a restarted attempt counts from zero
        start_attempt();
        send_bytes(8);
        start_attempt();
        send_bytes(8);
        event_check(1'b1, 1'b0, E_RETRY, "R3 restart clears count");
        start_attempt();
        send_bytes(9);
        event_check(1'b1, 1'b0, E_RETRY, "R3 count below window");
        start_attempt();
        send_bytes(10);
        event_check(1'b1, 1'b0, E_LATE, "R3 count reaches window");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule